// File: doc/BRIEF.md
# SD Card Block Write Data Transmitter

This block drives the data lines of an SD host while a write command moves one or more blocks to the card. In 1-bit bus mode only DAT0 carries data. In 4-bit mode all four lines carry data. Each block has the same frame: a start cycle driven low, the payload pulled byte by byte from an upstream stream, a separate CRC16 for every active lane, and one end cycle driven high. After the frame the host lets go of the lines and reads the card's 3-bit CRC status token on DAT0. It then waits while the card holds DAT0 low to signal that it is busy programming.

Software-visible framing choices are taken from the inputs at the moment a write starts: bus width, block length in bytes (1 to 2048), number of blocks, and a limit on busy cycles. A rejected status token, or a busy period longer than the limit, stops the write at once and sets an error flag. When every block has been sent and released, a one-cycle done pulse follows. Command issue, FIFOs, DMA and card selection are handled elsewhere.

Top module: `sd_wr_tx`

## Requirements
- R1: Every block opens with one start cycle driven low. In 1-bit mode only DAT0 is driven (enables 4'b0001). In 4-bit mode all four lines are driven (4'b1111). Outside the start, payload, CRC and end cycles the enables are 4'b0000.
- R2: Each block carries blk_len_i bytes (1 to 2048). In 1-bit mode each byte goes out MSB first on DAT0, one bit per cycle. In 4-bit mode the high nibble goes out before the low nibble, with nibble bit 3 on DAT3 down to bit 0 on DAT0.
- R3: Right after the payload, every active lane sends 16 cycles of its own CRC16 (polynomial x^16+x^12+x^5+1, initial value zero) over that lane's payload bits, MSB first. One end cycle follows, driven high on the active lanes, and then all lines are released.
- R4: One idle cycle after the end cycle, DAT0 is sampled on three consecutive cycles, with the first sample as the most significant bit. A token of 3'b010 accepts the block. Any other token, 3'b101 included, sets crc_err_o, drops all remaining blocks, and pulses done_o in the next cycle.
- R5: After an accepted token, no new block starts while DAT0 is sampled low. The next block's start cycle comes in the cycle right after the first high sample of DAT0.
- R6: If DAT0 is sampled low on more than busy_limit_i consecutive busy cycles, busy_to_o is set, the write stops, and done_o pulses in the next cycle. Exactly busy_limit_i low cycles are not a timeout.
- R7: A write sends blk_cnt_i blocks (1 or more), all with the same framing. done_o pulses for one cycle right after the last block's busy release. crc_err_o and busy_to_o keep their value until the next accepted start.
- R8: data_req_o pulses once for each byte, and data_i is taken in that same cycle. Each block produces exactly blk_len_i pulses.
- R9: start_i and the configuration inputs are ignored while a write is in progress.
- R10: During and after reset no line is driven, and done_o, data_req_o, crc_err_o and busy_to_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a write when the block is idle |
| wide_i | input | 1 | 1 selects 4-bit mode, 0 selects 1-bit mode |
| blk_len_i | input | 12 | Bytes per block, 1 to 2048 |
| blk_cnt_i | input | 16 | Number of blocks, 1 or more |
| busy_limit_i | input | 16 | Largest allowed run of busy cycles |
| data_i | input | 8 | Payload byte, taken when data_req_o is high |
| data_req_o | output | 1 | Takes one payload byte this cycle |
| dat_o | output | 4 | Values driven on DAT3..DAT0 |
| dat_oe_o | output | 4 | Output enables for DAT3..DAT0 |
| dat0_i | input | 1 | Sampled DAT0 level from the card |
| done_o | output | 1 | One-cycle pulse when the write ends |
| crc_err_o | output | 1 | Card rejected a block |
| busy_to_o | output | 1 | Busy period went past the limit |

## Verification
The assertions check on every cycle the properties that do not depend on payload: the start cycle is driven low, only the 1-lane or 4-lane enable pattern ever appears, the end cycle is driven high before release, no block starts while DAT0 is busy, error flags rise only with done_o, and the lines are idle during done. Only the bench's scenarios can show the rest. That covers bit ordering on the lanes, the per-lane CRC values, the exact cycle where the status token is sampled, the timeout boundary at busy_limit_i, aborting after a rejected token, and ignoring a start that arrives mid-write. Each of these needs a card model that checks the payload and answers with chosen tokens and busy lengths.

// File: rtl/sd_wr_pkg.sv
package sd_wr_pkg;
  localparam int unsigned LANES = 4;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [2:0]  STAT_OK  = 3'b010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DATA, ST_CRC, ST_END, ST_GAP, ST_STAT, ST_BUSY, ST_DONE
  } wr_state_e;
endpackage

// File: rtl/sd_wr_crc16.sv
module sd_wr_crc16
  import sd_wr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb    = bit_i ^ crc_q[15];
  assign bit_o = crc_q[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (upd_i)   crc_q <= {crc_q[14:0], 1'b0} ^ ({16{fb}} & CRC_POLY);
    else if (shift_i) crc_q <= {crc_q[14:0], 1'b0};
  end
endmodule

// File: rtl/sd_wr_busy_timer.sv
module sd_wr_busy_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expired_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (cnt_en_i && !expired_o) cnt_q <= cnt_q + TMO_W'(1);
  end
endmodule

// File: rtl/sd_wr_tx.sv
module sd_wr_tx
  import sd_wr_pkg::*;
#(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [TMO_W-1:0] busy_limit_i,
  input  logic [7:0]       data_i,
  output logic             data_req_o,
  output logic [3:0]       dat_o,
  output logic [3:0]       dat_oe_o,
  input  logic             dat0_i,
  output logic             done_o,
  output logic             crc_err_o,
  output logic             busy_to_o
);
  wr_state_e        st_q;
  logic             wide_q;
  logic [LEN_W-1:0] len_q, byte_rem_q;
  logic [CNT_W-1:0] blk_left_q;
  logic [TMO_W-1:0] limit_q;
  logic [7:0]       sh_q;
  logic [2:0]       slot_q;
  logic [3:0]       cnt_q;
  logic [1:0]       stat_q;
  logic             err_q, to_q;

  logic [LANES-1:0] mask, ser_bits, crc_bits;
  logic             last_slot, busy_expired;
  logic [2:0]       stat_word;

  assign mask      = wide_q ? 4'hF : 4'h1;
  assign last_slot = wide_q ? (slot_q == 3'd1) : (slot_q == 3'd7);
  assign ser_bits  = wide_q ? sh_q[7:4] : {3'b000, sh_q[7]};
  assign stat_word = {stat_q, dat0_i};

  assign data_req_o = (st_q == ST_START) ||
                      (st_q == ST_DATA && last_slot && byte_rem_q != '0);
  assign done_o     = (st_q == ST_DONE);
  assign crc_err_o  = err_q;
  assign busy_to_o  = to_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sd_wr_crc16 u_crc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (st_q == ST_START),
      .upd_i   (st_q == ST_DATA),
      .shift_i (st_q == ST_CRC),
      .bit_i   (ser_bits[l]),
      .bit_o   (crc_bits[l])
    );
  end

  sd_wr_busy_timer #(.TMO_W(TMO_W)) u_busy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (st_q != ST_BUSY),
    .cnt_en_i  (st_q == ST_BUSY && !dat0_i),
    .limit_i   (limit_q),
    .expired_o (busy_expired)
  );

  // inactive lanes idle high, undriven
  always_comb begin
    dat_o    = 4'hF;
    dat_oe_o = 4'h0;
    unique case (st_q)
      ST_START: begin dat_o = ~mask;                 dat_oe_o = mask; end
      ST_DATA:  begin dat_o = ser_bits | ~mask;      dat_oe_o = mask; end
      ST_CRC:   begin dat_o = crc_bits | ~mask;      dat_oe_o = mask; end
      ST_END:   begin dat_o = 4'hF;                  dat_oe_o = mask; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wide_q     <= 1'b0;
      len_q      <= '0;
      byte_rem_q <= '0;
      blk_left_q <= '0;
      limit_q    <= '0;
      sh_q       <= '0;
      slot_q     <= '0;
      cnt_q      <= '0;
      stat_q     <= '0;
      err_q      <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          wide_q     <= wide_i;
          len_q      <= blk_len_i;
          blk_left_q <= blk_cnt_i;
          limit_q    <= busy_limit_i;
          err_q      <= 1'b0;
          to_q       <= 1'b0;
          st_q       <= ST_START;
        end
        ST_START: begin
          sh_q       <= data_i;
          byte_rem_q <= len_q - LEN_W'(1);
          slot_q     <= '0;
          st_q       <= ST_DATA;
        end
        ST_DATA: begin
          if (last_slot) begin
            slot_q <= '0;
            if (byte_rem_q == '0) begin
              cnt_q <= '0;
              st_q  <= ST_CRC;
            end else begin
              sh_q       <= data_i;
              byte_rem_q <= byte_rem_q - LEN_W'(1);
            end
          end else begin
            sh_q   <= wide_q ? {sh_q[3:0], 4'b0000} : {sh_q[6:0], 1'b0};
            slot_q <= slot_q + 3'd1;
          end
        end
        ST_CRC: begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd15) st_q <= ST_END;
        end
        ST_END: st_q <= ST_GAP;
        ST_GAP: begin
          cnt_q <= '0;
          st_q  <= ST_STAT;
        end
        ST_STAT: begin
          stat_q <= stat_word[1:0];
          cnt_q  <= cnt_q + 4'd1;
          if (cnt_q == 4'd2) begin
            if (stat_word == STAT_OK) st_q <= ST_BUSY;
            else begin
              err_q <= 1'b1;
              st_q  <= ST_DONE;
            end
          end
        end
        ST_BUSY: begin
          if (dat0_i) begin
            if (blk_left_q <= CNT_W'(1)) st_q <= ST_DONE;
            else begin
              blk_left_q <= blk_left_q - CNT_W'(1);
              st_q       <= ST_START;
            end
          end else if (busy_expired) begin
            to_q <= 1'b1;
            st_q <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_wr_tx_chk.sv
module sd_wr_tx_chk
  import sd_wr_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic [3:0] dat_o,
  input logic [3:0] dat_oe_o,
  input logic      dat0_i,
  input logic      data_req_o,
  input logic      done_o,
  input logic      crc_err_o,
  input logic      busy_to_o,
  input wr_state_e st_i
);
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|dat_oe_o) |-> ((dat_o & dat_oe_o) == 4'h0));  // R1
  AST_LANE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_oe_o == 4'h0) || (dat_oe_o == 4'h1) || (dat_oe_o == 4'hF));  // R1
  AST_END_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|dat_oe_o) |-> ($past(dat_o & dat_oe_o) == $past(dat_oe_o)));  // R3
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_BUSY && !dat0_i) |=> (st_i != ST_START));  // R5
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_o) |-> done_o);  // R4
  AST_TO_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_to_o) |-> done_o);  // R6
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crc_err_o && busy_to_o));  // R4
  AST_REQ_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_o |-> (dat_oe_o != 4'h0));  // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dat_oe_o == 4'h0 && !data_req_o));  // R7
endmodule

bind sd_wr_tx sd_wr_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dat_o      (dat_o),
  .dat_oe_o   (dat_oe_o),
  .dat0_i     (dat0_i),
  .data_req_o (data_req_o),
  .done_o     (done_o),
  .crc_err_o  (crc_err_o),
  .busy_to_o  (busy_to_o),
  .st_i       (st_q)
);

// File: tb/sd_wr_tx_tb_top.sv
module sd_wr_tx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, wide_i = 1'b0, dat0_i = 1'b1;
  logic [11:0] blk_len_i = '0;
  logic [15:0] blk_cnt_i = '0, busy_limit_i = '0;
  logic [7:0]  data_i;
  logic        data_req_o, done_o, crc_err_o, busy_to_o;
  logic [3:0]  dat_o, dat_oe_o;

  int n_tests = 0, n_fail = 0, tx_idx = 0, rx_idx = 0, req_cnt = 0;
  bit fin = 0;

  always #2 clk_i = ~clk_i;

  sd_wr_tx dut_i (.*);

  function automatic logic [7:0] pat(int i);
    return 8'(((i * 29) + (i >> 2)) ^ 32'h5A);
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return (b ^ c[15]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
  endfunction

  assign data_i = pat(tx_idx);
  always @(posedge clk_i) if (data_req_o) begin
    tx_idx  <= tx_idx + 1;
    req_cnt <= req_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string msg,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic go(input bit w, input int len, input int cnt, input int lim);
    @(negedge clk_i);
    wide_i = w; blk_len_i = 12'(len); blk_cnt_i = 16'(cnt);
    busy_limit_i = 16'(lim); start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
  endtask

  // kind: 0 next block follows, 1 last block, 2 token rejected, 3 busy timeout
  task automatic card_block(input int len, input bit wide, input bit in_start,
                            input logic [2:0] tok, input int busy_n, input int kind);
    logic [3:0]  mask;
    logic [15:0] crc [4];
    logic [15:0] rx  [4];
    bit data_ok, oe_ok, busy_ok;
    int w;
    logic [7:0] bad_g, bad_e;
    mask = wide ? 4'hF : 4'h1;
    data_ok = 1; oe_ok = 1; busy_ok = 1; w = 0; bad_g = '0; bad_e = '0;
    for (int l = 0; l < 4; l++) begin crc[l] = '0; rx[l] = '0; end
    if (!in_start) begin
      do begin @(negedge clk_i); w++; end while (dat_oe_o == 4'h0 && w < 300);
    end
    chk(dat_oe_o == mask, "R1", "start enables", dat_oe_o, mask);
    chk((dat_o & mask) == 4'h0, "R1", "start bits low", dat_o & mask, 0);
    for (int b = 0; b < len; b++) begin
      logic [7:0] e, g;
      e = pat(rx_idx); rx_idx++; g = '0;
      if (wide) begin
        for (int h = 1; h >= 0; h--) begin
          @(negedge clk_i);
          if (dat_oe_o != mask) oe_ok = 0;
          for (int l = 0; l < 4; l++) begin
            g[h*4+l] = dat_o[l];
            crc[l] = crc_step(crc[l], dat_o[l]);
          end
        end
      end else begin
        for (int k = 7; k >= 0; k--) begin
          @(negedge clk_i);
          if (dat_oe_o != mask) oe_ok = 0;
          g[k] = dat_o[0];
          crc[0] = crc_step(crc[0], dat_o[0]);
        end
      end
      if (g != e && data_ok) begin data_ok = 0; bad_g = g; bad_e = e; end
    end
    chk(data_ok, "R2", "payload bits", bad_g, bad_e);
    chk(oe_ok, "R1", "lanes driven during payload", 0, 1);
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk_i);
      for (int l = 0; l < 4; l++) rx[l][k] = dat_o[l];
    end
    for (int l = 0; l < 4; l++)
      if (mask[l]) chk(rx[l] == crc[l], "R3", "lane crc16", rx[l], crc[l]);
    @(negedge clk_i);
    chk(dat_oe_o == mask && (dat_o & mask) == mask, "R3", "end bits high",
        {dat_oe_o, dat_o}, {mask, mask});
    @(negedge clk_i);
    chk(dat_oe_o == 4'h0, "R3", "lines released after end", dat_oe_o, 0);
    dat0_i = 1'b1;
    for (int k = 2; k >= 0; k--) begin
      @(negedge clk_i);
      dat0_i = tok[k];
    end
    if (kind == 2) begin
      @(negedge clk_i);
      dat0_i = 1'b1;
      chk(done_o && crc_err_o && !busy_to_o, "R4", "rejected token ends write",
          {done_o, crc_err_o, busy_to_o}, 3'b110);
      return;
    end
    for (int i = 0; i < busy_n; i++) begin
      @(negedge clk_i);
      if (dat_oe_o != 4'h0 || done_o) busy_ok = 0;
      dat0_i = 1'b0;
    end
    if (kind == 3) begin
      @(negedge clk_i);
      dat0_i = 1'b1;
      chk(busy_ok, "R6", "no early timeout", 0, 1);
      chk(done_o && busy_to_o && !crc_err_o, "R6", "busy timeout",
          {done_o, busy_to_o, crc_err_o}, 3'b110);
      return;
    end
    @(negedge clk_i);
    if (dat_oe_o != 4'h0 || done_o) busy_ok = 0;
    dat0_i = 1'b1;
    chk(busy_ok, "R5", "held off while busy", 0, 1);
    @(negedge clk_i);
    if (kind == 0)
      chk(dat_oe_o == mask, "R5", "next block right after release", dat_oe_o, mask);
    else
      chk(done_o && !crc_err_o && !busy_to_o, "R7", "done after last block",
          {done_o, crc_err_o, busy_to_o}, 3'b100);
  endtask

  task automatic quiet(input int n, input string req);
    bit ok;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (dat_oe_o != 4'h0 || data_req_o || done_o) ok = 0;
    end
    chk(ok, req, "no further blocks", 0, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk(dat_oe_o == 4'h0 && !done_o && !data_req_o && !crc_err_o && !busy_to_o,
        "R10", "reset outputs", {dat_oe_o, done_o, data_req_o, crc_err_o, busy_to_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(dat_oe_o == 4'h0 && !done_o, "R10", "idle after reset", dat_oe_o, 0);
  endtask

  task automatic t_single_narrow();
    int r0;
    r0 = req_cnt;
    go(1'b0, 4, 1, 10);
    card_block(4, 1'b0, 1'b0, 3'b010, 3, 1);
    chk(req_cnt - r0 == 4, "R8", "byte requests single", req_cnt - r0, 4);
  endtask

  task automatic t_multi_wide();
    int r0;
    r0 = req_cnt;
    go(1'b1, 16, 3, 4);
    card_block(16, 1'b1, 1'b0, 3'b010, 4, 0);  // busy equal to limit: R6 boundary
    card_block(16, 1'b1, 1'b1, 3'b010, 0, 0);
    card_block(16, 1'b1, 1'b1, 3'b010, 2, 1);
    chk(req_cnt - r0 == 48, "R8", "byte requests multi", req_cnt - r0, 48);
    chk(!busy_to_o, "R6", "limit reached not timeout", busy_to_o, 0);
  endtask

  task automatic t_token_reject();
    int r0;
    r0 = req_cnt;
    go(1'b1, 8, 3, 10);
    card_block(8, 1'b1, 1'b0, 3'b101, 0, 2);
    quiet(40, "R4");
    chk(req_cnt - r0 == 8, "R4", "remaining blocks dropped", req_cnt - r0, 8);
  endtask

  task automatic t_token_other();
    go(1'b0, 2, 2, 10);
    card_block(2, 1'b0, 1'b0, 3'b010, 1, 0);
    card_block(2, 1'b0, 1'b1, 3'b000, 0, 2);
    quiet(20, "R4");
  endtask

  task automatic t_timeout();
    go(1'b0, 3, 2, 5);
    card_block(3, 1'b0, 1'b0, 3'b010, 6, 3);
    quiet(20, "R6");
    chk(busy_to_o && !crc_err_o, "R7", "flag held until next start",
        {busy_to_o, crc_err_o}, 2'b10);
  endtask

  task automatic t_ignore_start();
    int r0;
    r0 = req_cnt;
    go(1'b1, 32, 1, 10);
    chk(!busy_to_o && !crc_err_o, "R7", "flags cleared by start",
        {busy_to_o, crc_err_o}, 0);
    fork
      card_block(32, 1'b1, 1'b0, 3'b010, 2, 1);
      begin
        repeat (20) @(negedge clk_i);
        start_i = 1'b1; wide_i = 1'b0; blk_len_i = 12'd5; blk_cnt_i = 16'd4;
        @(negedge clk_i);
        start_i = 1'b0;
      end
    join
    quiet(10, "R9");
    chk(req_cnt - r0 == 32, "R9", "mid-write start ignored", req_cnt - r0, 32);
  endtask

  task automatic t_len_edges();
    int r0;
    r0 = req_cnt;
    go(1'b1, 1, 2, 10);
    card_block(1, 1'b1, 1'b0, 3'b010, 1, 0);
    card_block(1, 1'b1, 1'b1, 3'b010, 1, 1);
    chk(req_cnt - r0 == 2, "R2", "one-byte blocks", req_cnt - r0, 2);
    r0 = req_cnt;
    go(1'b1, 2048, 1, 10);
    card_block(2048, 1'b1, 1'b0, 3'b010, 1, 1);
    chk(req_cnt - r0 == 2048, "R2", "maximum block length", req_cnt - r0, 2048);
  endtask

  initial begin
    t_reset();
    t_single_narrow();
    t_multi_wide();
    t_token_reject();
    t_token_other();
    t_timeout();
    t_ignore_start();
    t_len_edges();
    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule